// File: doc/BRIEF.md
# Execution Unit with Status Flags

This block is the combinational arithmetic and logic stage of a small 16-bit processor. The decode stage supplies an operation code, two 16-bit operands, a 4-bit immediate field and the current status word. Within the same cycle the block returns a 16-bit result, a writeback enable and a new status word. In the new status word only the zero, carry and negative flag bits change.

The supported operations are add, add with carry, compare, negate, AND, OR, XOR, NOT, shifts whose count comes from a register, and immediate forms of add, AND, OR and the shifts. The 4-bit immediates use compact encodings. For add-immediate and the logical-shift immediate, a value of zero stands for eight. For the arithmetic-shift immediate, a count of zero stands for sixteen. Right shifts put the last bit shifted out into the carry flag. Logical operations leave the carry flag as it was.

A separate condition evaluator reads the incoming flags and a 4-bit branch condition code. It reports whether a branch is taken, or that the code is not a valid condition.

Top module: `exu_alu`

## Requirements
- R1: Status word flags sit at bit 2 (Z, zero), bit 3 (C, carry) and bit 4 (N, negative). `sr_out` equals `sr_in` in every other bit position.
- R2: ADD (op 0) computes opa+opb and ADC (op 1) computes opa+opb+C. NEG (op 3) computes 0-opb. Each uses a 17-bit result: Z is set when the low 16 bits are zero, N copies bit 15 and C copies bit 16.
- R3: CMP (op 2) forms opa-opb as a 17-bit value and sets Z, N and C from it as in R2, with `wr_en` low. Every other op drives `wr_en` high.
- R4: AND (op 4), OR (op 5), XOR (op 6) and NOT (op 7, which inverts opb) update only N and Z. The same holds for ANDI (op 12) and ORI (op 13). ANDI and ORI use `imm` sign-extended to 16 bits, with no zero substitution. C keeps its incoming value for all of these ops.
- R5: ADDI (op 11) adds `imm` sign-extended to 16 bits, with the value 0 replaced by +8. Flags follow R2.
- R6: Register-count shifts shift opa by opb: LSL (op 8), LSR (op 9), ASR (op 10, which fills with the sign bit). C takes the last bit shifted out. A count of 0 returns opa unchanged and clears C.
- R7: A register count of 16 or more makes LSL and LSR return 0 with C clear. ASR returns sixteen copies of the sign bit, with C equal to the sign bit.
- R8: LSI (op 14) shifts opa by an immediate. imm[3] set means shift right and clear means shift left. imm[2:0] is the count, with 0 meaning 8. C takes the last bit shifted out.
- R9: ASRI (op 15) shifts opa arithmetically right by `imm`, with 0 meaning 16. C takes the last bit shifted out.
- R10: The branch condition codes and their meanings are:
  - 0: always
  - 1: never
  - 2: Z set
  - 3: Z clear
  - 4: N set
  - 5: N clear
  - 6: C set
  - 7: C clear
  - 8: Z clear and C clear
  - 9: Z set or C set
- R11: Condition codes 10 to 15 raise `br_bad` and keep `br_take` low. Codes 0 to 9 keep `br_bad` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| opa | input | 16 | Destination-side operand |
| opb | input | 16 | Source-side operand or shift count |
| imm | input | 4 | Immediate field |
| sr_in | input | 16 | Current status word |
| cond | input | 4 | Branch condition code |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Result is to be written back |
| sr_out | output | 16 | Updated status word |
| br_take | output | 1 | Branch condition holds |
| br_bad | output | 1 | Condition code is invalid |

## Verification
The embedded assertions are checked whenever the inputs are known. They cover these properties:
- Compare never writes back.
- Logical ops hold the carry flag.
- A zero-count register shift is transparent and clears carry.
- The taken and invalid branch outputs never rise together.
- The never condition is never taken.

The exact arithmetic values cannot be shown by a property, so the bench's vectors and directed cases cover them. These include the carry and borrow outputs, the zero-means-eight and zero-means-sixteen immediate encodings, saturation of large register counts, and the truth table of every condition code across all flag combinations.

// File: rtl/exu_alu.sv
module exu_alu (
  input  logic [3:0]  op,
  input  logic [15:0] opa,
  input  logic [15:0] opb,
  input  logic [3:0]  imm,
  input  logic [15:0] sr_in,
  input  logic [3:0]  cond,
  output logic [15:0] result,
  output logic        wr_en,
  output logic [15:0] sr_out,
  output logic        br_take,
  output logic        br_bad
);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADC  = 4'd1;
  localparam logic [3:0] OP_CMP  = 4'd2;
  localparam logic [3:0] OP_NEG  = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_NOT  = 4'd7;
  localparam logic [3:0] OP_LSL  = 4'd8;
  localparam logic [3:0] OP_LSR  = 4'd9;
  localparam logic [3:0] OP_ASR  = 4'd10;
  localparam logic [3:0] OP_ADDI = 4'd11;
  localparam logic [3:0] OP_ANDI = 4'd12;
  localparam logic [3:0] OP_ORI  = 4'd13;
  localparam logic [3:0] OP_LSI  = 4'd14;
  localparam logic [3:0] OP_ASRI = 4'd15;

  localparam int ZB = 2;
  localparam int CB = 3;
  localparam int NB = 4;

  logic        f_z, f_c, f_n;
  logic [15:0] imm_sx, imm_add;
  logic        reg_big;
  logic [4:0]  sh_n;
  logic [31:0] shl_w, shr_w;
  logic signed [31:0] asr_src, asr_w;
  logic [16:0] arith;
  logic [15:0] res;
  logic        c_new;

  assign f_z = sr_in[ZB];
  assign f_c = sr_in[CB];
  assign f_n = sr_in[NB];

  assign imm_sx  = {{12{imm[3]}}, imm};
  assign imm_add = (imm == 4'd0) ? 16'd8 : imm_sx;
  assign reg_big = |opb[15:4];

  always_comb begin
    case (op)
      OP_ASR:  sh_n = reg_big ? 5'd16 : {1'b0, opb[3:0]};
      OP_LSI:  sh_n = (imm[2:0] == 3'd0) ? 5'd8 : {2'b00, imm[2:0]};
      OP_ASRI: sh_n = (imm == 4'd0) ? 5'd16 : {1'b0, imm};
      default: sh_n = {1'b0, opb[3:0]};
    endcase
  end

  assign shl_w   = {16'h0000, opa} << sh_n;
  assign shr_w   = {opa, 16'h0000} >> sh_n;
  assign asr_src = {opa, 16'h0000};
  assign asr_w   = asr_src >>> sh_n;

  always_comb begin
    case (op)
      OP_ADC:  arith = {1'b0, opa} + {1'b0, opb} + {16'd0, f_c};
      OP_CMP:  arith = {1'b0, opa} - {1'b0, opb};
      OP_NEG:  arith = 17'd0 - {1'b0, opb};
      OP_ADDI: arith = {1'b0, opa} + {1'b0, imm_add};
      default: arith = {1'b0, opa} + {1'b0, opb};
    endcase
  end

  always_comb begin
    res   = arith[15:0];
    c_new = arith[16];
    case (op)
      OP_AND:  begin res = opa & opb;    c_new = f_c; end
      OP_OR:   begin res = opa | opb;    c_new = f_c; end
      OP_XOR:  begin res = opa ^ opb;    c_new = f_c; end
      OP_NOT:  begin res = ~opb;         c_new = f_c; end
      OP_ANDI: begin res = opa & imm_sx; c_new = f_c; end
      OP_ORI:  begin res = opa | imm_sx; c_new = f_c; end
      OP_LSL: begin
        res   = reg_big ? 16'd0 : shl_w[15:0];
        c_new = reg_big ? 1'b0  : shl_w[16];
      end
      OP_LSR: begin
        res   = reg_big ? 16'd0 : shr_w[31:16];
        c_new = reg_big ? 1'b0  : shr_w[15];
      end
      OP_ASR, OP_ASRI: begin
        res   = asr_w[31:16];
        c_new = asr_w[15];
      end
      OP_LSI: begin
        res   = imm[3] ? shr_w[31:16] : shl_w[15:0];
        c_new = imm[3] ? shr_w[15]    : shl_w[16];
      end
      default: ;
    endcase
  end

  assign result = res;
  assign wr_en  = (op != OP_CMP);
  assign sr_out = {sr_in[15:NB+1], res[15], c_new, (res == 16'd0), sr_in[ZB-1:0]};

  always_comb begin
    br_bad  = 1'b0;
    br_take = 1'b0;
    case (cond)
      4'd0: br_take = 1'b1;
      4'd1: br_take = 1'b0;
      4'd2: br_take = f_z;
      4'd3: br_take = !f_z;
      4'd4: br_take = f_n;
      4'd5: br_take = !f_n;
      4'd6: br_take = f_c;
      4'd7: br_take = !f_c;
      4'd8: br_take = !f_z && !f_c;
      4'd9: br_take = f_z || f_c;
      default: br_bad = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown({op, opa, opb, imm, sr_in, cond})) begin
      AST_CMP_NO_WB: assert (op != OP_CMP || !wr_en); // R3
      AST_LOGIC_KEEPS_C: assert (!(op inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ANDI, OP_ORI}) || sr_out[CB] == sr_in[CB]); // R4
      AST_SHIFT0_TRANSPARENT: assert (!(op inside {OP_LSL, OP_LSR, OP_ASR} && opb == 16'd0) || (result == opa && !sr_out[CB])); // R6
      AST_BR_EXCLUSIVE: assert (!(br_take && br_bad)); // R11
      AST_NEVER_TAKEN: assert (cond != 4'd1 || !br_take); // R10
    end
  end

endmodule

// File: tb/exu_alu_tb.sv
module exu_alu_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  op, imm, cond;
  logic [15:0] opa, opb, sr_in;
  logic [15:0] result, sr_out;
  logic        wr_en, br_take, br_bad;

  exu_alu u_dut (
    .op(op), .opa(opa), .opb(opb), .imm(imm), .sr_in(sr_in), .cond(cond),
    .result(result), .wr_en(wr_en), .sr_out(sr_out),
    .br_take(br_take), .br_bad(br_bad)
  );

  int n_chk = 0;
  int n_fail = 0;
  int wd = 0;
  bit done = 0;

  localparam int NV = 37;
  localparam logic [74:0] VEC [NV] = '{
    {4'd0,  16'h7FFF, 16'h0001, 4'h0, 16'h0000, 16'h8000, 3'b100},
    {4'd0,  16'hFFFF, 16'h0001, 4'h0, 16'h0000, 16'h0000, 3'b011},
    {4'd1,  16'h0001, 16'h0001, 4'h0, 16'h0008, 16'h0003, 3'b000},
    {4'd1,  16'hFFFF, 16'h0000, 4'h0, 16'h0008, 16'h0000, 3'b011},
    {4'd2,  16'h0005, 16'h0005, 4'h0, 16'h0000, 16'h0000, 3'b001},
    {4'd2,  16'h0003, 16'h0005, 4'h0, 16'h0000, 16'hFFFE, 3'b110},
    {4'd3,  16'h0000, 16'h0001, 4'h0, 16'h0000, 16'hFFFF, 3'b110},
    {4'd3,  16'h1234, 16'h0000, 4'h0, 16'h0000, 16'h0000, 3'b001},
    {4'd4,  16'hF0F0, 16'h0F0F, 4'h0, 16'h0008, 16'h0000, 3'b011},
    {4'd6,  16'hFFFF, 16'h00FF, 4'h0, 16'h0000, 16'hFF00, 3'b100},
    {4'd7,  16'h0000, 16'hFFFF, 4'h0, 16'h0008, 16'h0000, 3'b011},
    {4'd5,  16'h8000, 16'h0001, 4'h0, 16'h0000, 16'h8001, 3'b100},
    {4'd12, 16'h1234, 16'h0000, 4'h8, 16'h0000, 16'h1230, 3'b000},
    {4'd13, 16'h0000, 16'h0000, 4'h0, 16'h0000, 16'h0000, 3'b001},
    {4'd13, 16'h0000, 16'h0000, 4'h7, 16'h0000, 16'h0007, 3'b000},
    {4'd11, 16'h0005, 16'h0000, 4'h0, 16'h0000, 16'h000D, 3'b000},
    {4'd11, 16'h0005, 16'h0000, 4'hF, 16'h0000, 16'h0004, 3'b010},
    {4'd11, 16'h0000, 16'h0000, 4'h8, 16'h0000, 16'hFFF8, 3'b100},
    {4'd8,  16'h8001, 16'h0001, 4'h0, 16'h0000, 16'h0002, 3'b010},
    {4'd8,  16'h0001, 16'h0000, 4'h0, 16'h0008, 16'h0001, 3'b000},
    {4'd9,  16'h0003, 16'h0001, 4'h0, 16'h0000, 16'h0001, 3'b010},
    {4'd9,  16'h8000, 16'h000F, 4'h0, 16'h0000, 16'h0001, 3'b000},
    {4'd9,  16'hFFFF, 16'h0010, 4'h0, 16'h0008, 16'h0000, 3'b001},
    {4'd8,  16'hFFFF, 16'h0100, 4'h0, 16'h0008, 16'h0000, 3'b001},
    {4'd10, 16'h8000, 16'h0004, 4'h0, 16'h0000, 16'hF800, 3'b100},
    {4'd10, 16'h8001, 16'h0001, 4'h0, 16'h0000, 16'hC000, 3'b110},
    {4'd10, 16'h8000, 16'h0014, 4'h0, 16'h0000, 16'hFFFF, 3'b110},
    {4'd10, 16'h4000, 16'h0000, 4'h0, 16'h0008, 16'h4000, 3'b000},
    {4'd14, 16'h00FF, 16'h0000, 4'h0, 16'h0000, 16'hFF00, 3'b100},
    {4'd14, 16'h01FF, 16'h0000, 4'h0, 16'h0000, 16'hFF00, 3'b110},
    {4'd14, 16'h0180, 16'h0000, 4'h8, 16'h0000, 16'h0001, 3'b010},
    {4'd14, 16'h0006, 16'h0000, 4'h9, 16'h0008, 16'h0003, 3'b000},
    {4'd14, 16'h4000, 16'h0000, 4'h2, 16'h0000, 16'h0000, 3'b011},
    {4'd15, 16'h8000, 16'h0000, 4'h0, 16'h0000, 16'hFFFF, 3'b110},
    {4'd15, 16'h7FFF, 16'h0000, 4'h0, 16'h0000, 16'h0000, 3'b001},
    {4'd15, 16'h0010, 16'h0000, 4'h5, 16'h0000, 16'h0000, 3'b011},
    {4'd15, 16'hF000, 16'h0000, 4'h4, 16'h0000, 16'hFF00, 3'b100}
  };

  function automatic string tag_of(input logic [3:0] o, input logic [15:0] b);
    case (o)
      4'd0, 4'd1, 4'd3: return "R2";
      4'd2: return "R3";
      4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd13: return "R4";
      4'd11: return "R5";
      4'd8, 4'd9, 4'd10: return (b >= 16) ? "R7" : "R6";
      4'd14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] i, input logic [15:0] s, input logic [3:0] c);
    @(negedge clk);
    op = o; opa = a; opb = b; imm = i; sr_in = s; cond = c;
    #1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected < 20000", wd);
      finish_up();
    end
  end

  initial begin
    op = 0; opa = 0; opb = 0; imm = 0; sr_in = 0; cond = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle inputs after reset: 0+0 sets only Z, always-branch taken
    apply(4'd0, 16'h0, 16'h0, 4'h0, 16'h0, 4'd0);
    check("R1", "idle sr_out", {16'h0, sr_out}, 32'h0004);
    check("R2", "idle result", {16'h0, result}, 32'h0);
    check("R10", "idle br_take", {31'h0, br_take}, 32'h1);

    for (int k = 0; k < NV; k++) begin
      logic [74:0] v;
      v = VEC[k];
      apply(v[74:71], v[70:55], v[54:39], v[38:35], v[34:19], 4'd0);
      check(tag_of(v[74:71], v[54:39]), "result", {16'h0, result}, {16'h0, v[18:3]});
      check(tag_of(v[74:71], v[54:39]), "N,C,Z", {29'h0, sr_out[4], sr_out[3], sr_out[2]}, {29'h0, v[2:0]});
      check("R3", "wr_en", {31'h0, wr_en}, {31'h0, (v[74:71] != 4'd2)});
    end

    // R1: bits outside the flags pass through
    apply(4'd0, 16'h0, 16'h0, 4'h0, 16'hFFE3, 4'd0);
    check("R1", "sr_out pass", {16'h0, sr_out}, 32'hFFE7);
    apply(4'd4, 16'hFFFF, 16'h0001, 4'h0, 16'hFFFF, 4'd0);
    check("R1", "sr_out keepC", {16'h0, sr_out}, 32'hFFEB);

    // R10 / R11: every condition against every flag combination
    for (int f = 0; f < 8; f++) begin
      for (int c = 0; c < 16; c++) begin
        logic nf, cf, zf, et, eb;
        nf = f[2]; cf = f[1]; zf = f[0];
        eb = 1'b0;
        case (c)
          0: et = 1'b1;
          1: et = 1'b0;
          2: et = zf;
          3: et = !zf;
          4: et = nf;
          5: et = !nf;
          6: et = cf;
          7: et = !cf;
          8: et = !zf && !cf;
          9: et = zf || cf;
          default: begin et = 1'b0; eb = 1'b1; end
        endcase
        apply(4'd0, 16'h0001, 16'h0001, 4'h0, {11'h0, f[2:0], 2'b00}, c[3:0]);
        check((c < 10) ? "R10" : "R11", "br_take", {31'h0, br_take}, {31'h0, et});
        check("R11", "br_bad", {31'h0, br_bad}, {31'h0, eb});
      end
    end

    finish_up();
  end

endmodule